// File: doc/BRIEF.md
# Scanline Background Fetch Scheduler

This block decides, for every clock of a scanline, whether one of four background layers issues a video-memory read and what that read is for: a map entry, a line of tile data, or a bitmap pixel. It does not count cycles itself. An external line-cycle counter drives it, together with a visible-line flag and the current video mode. It also takes a per-layer enable, a per-layer colour depth and the low three bits of each layer's horizontal scroll. Each output is registered, so the answer for the cycle presented on one clock appears after the next rising edge.

In the text modes, each layer works through 32-cycle tile slots. Each slot holds one map read, followed by two or four tile reads depending on colour depth. The four layers are interleaved one cycle apart. A fine horizontal scroll moves the start of a layer earlier by four cycles per pixel of scroll. The residue of the cycle modulo four therefore still identifies the layer, and two enabled layers never compete for the same cycle. In the affine mode, map and tile reads for layers 3 and 2 alternate in 4-cycle groups. The bitmap modes give layer 2 one pixel read per group. All fetching stops after the cut-off cycle, even when more slots were issued than the visible width needs.

Top module: `bg_fetch_sched`

## Requirements
- R1: All outputs are registered. The result for the line cycle presented before a rising edge is visible after that edge. While reset is low, every output is 0. Fetch kind codes are: 0 = none, 1 = map entry, 2 = tile data, 3 = bitmap pixel.
- R2: No fetch is issued when line_vis is 0 or when line_cyc is greater than 1005.
- R3: In a text role, layer k starts at cycle S = 31 - 4*f, where f is bits [3k+2:3k] of fine_scroll. Before S, layer k issues nothing. From S onward, d = cycle - S is split into 32-cycle slots, and fetch_idx carries the slot number d/32.
- R4: In a text role, layer k issues a map fetch at slot offset k. At 4 bits per pixel (layer_8bpp[k] = 0), it issues tile fetches at slot offsets 4+k and 20+k, and nothing at any other offset.
- R5: At 8 bits per pixel (layer_8bpp[k] = 1), a text layer issues tile fetches at slot offsets 4+k, 12+k, 20+k and 28+k.
- R6: Text slots continue to be issued after the 30 or 31 that the visible width needs, up to and including cycle 1005.
- R7: In video mode 2, from cycle 31 onward, position p = (cycle-31) mod 4 fetches as follows: p=0 is the layer 3 map, p=1 is the layer 3 tile, p=2 is the layer 2 map, p=3 is the layer 2 tile. fetch_idx is the group number (cycle-31)/4. Before cycle 31 nothing is fetched.
- R8: In video modes 3, 4 and 5, only layer 2 fetches. It issues one bitmap fetch at position p=3 of each group from cycle 31 onward, with fetch_idx equal to the group number.
- R9: In video mode 1, layers 0 and 1 follow the text rules R3 to R5. Layer 2 follows the layer 2 rules of R7. Layer 3 never fetches.
- R10: A layer whose bit in layer_on is 0 issues no fetch. Video modes 6 and 7 issue no fetch at all. At most one fetch is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_cyc | input | CYC_W | Current cycle within the scanline |
| line_vis | input | 1 | High on lines that are displayed |
| vid_mode | input | 3 | 0 text, 1 mixed, 2 affine, 3-5 bitmap |
| layer_on | input | 4 | Per-layer enable |
| layer_8bpp | input | 4 | Per-layer colour depth, 1 = 8 bits per pixel |
| fine_scroll | input | 12 | Horizontal scroll mod 8, 3 bits per layer |
| fetch_vld | output | 1 | A fetch is issued this cycle |
| fetch_layer | output | 2 | Layer issuing the fetch |
| fetch_kind | output | 2 | 0 none, 1 map, 2 tile, 3 bitmap |
| fetch_idx | output | IDX_W | Tile slot (text) or pixel group (affine, bitmap) |

## Verification
The state that can go wrong is the lane decode from the cycle residue, the scroll-shifted slot offset and the start comparison. A fault in any of them shows at the ports on the very next cycle as a fetch from the wrong layer, a wrong kind, or an index off by one slot. A start cycle that is wrong by four cycles shows up at the first slot of a scrolled layer. A cut-off that is off by one shows up only at cycle 1005 or 1006. The bench therefore compares every cycle of whole lines against an independent reference. It also pins the start, depth and cut-off corners with fixed expected values.

// File: rtl/bg_fetch_sched.sv
module bg_fetch_sched #(
  parameter int CYC_W     = 11,
  parameter int IDX_W     = 8,
  parameter int FIRST_CYC = 31,
  parameter int LAST_CYC  = 1005
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] line_cyc,
  input  logic             line_vis,
  input  logic [2:0]       vid_mode,
  input  logic [3:0]       layer_on,
  input  logic [3:0]       layer_8bpp,
  input  logic [11:0]      fine_scroll,
  output logic             fetch_vld,
  output logic [1:0]       fetch_layer,
  output logic [1:0]       fetch_kind,
  output logic [IDX_W-1:0] fetch_idx
);
  localparam int RW = CYC_W + 2;
  localparam logic [1:0] K_NONE = 2'd0, K_MAP = 2'd1, K_TILE = 2'd2, K_BMP = 2'd3;

  logic signed [RW-1:0] rel, txt_d;
  logic [1:0]       lane;
  logic [2:0]       fine_k, quad;
  logic             in_win, text_role;
  logic             nv;
  logic [1:0]       nl, nk;
  logic [IDX_W-1:0] ni;

  assign rel       = $signed({2'b00, line_cyc}) - $signed(RW'(FIRST_CYC));
  assign lane      = rel[1:0];
  assign fine_k    = fine_scroll[3*lane +: 3];
  assign txt_d     = rel + $signed({{(RW-5){1'b0}}, fine_k, 2'b00});
  assign quad      = txt_d[4:2];
  assign in_win    = line_vis && (line_cyc <= CYC_W'(LAST_CYC));
  assign text_role = (vid_mode == 3'd0) || (vid_mode == 3'd1 && !lane[1]);

  always_comb begin
    nl = lane;
    nk = K_NONE;
    ni = '0;
    if (vid_mode <= 3'd1 && text_role) begin
      if (!txt_d[RW-1]) begin
        ni = IDX_W'(txt_d[RW-1:5]);
        if (quad == 3'd0)                                nk = K_MAP;
        else if (quad == 3'd1 || quad == 3'd5)           nk = K_TILE;
        else if (layer_8bpp[lane] && (quad == 3'd3 || quad == 3'd7)) nk = K_TILE;
      end
    end else if (vid_mode <= 3'd2) begin
      if (!rel[RW-1]) begin
        nl = lane[1] ? 2'd2 : 2'd3;
        nk = lane[0] ? K_TILE : K_MAP;
        ni = IDX_W'(rel[RW-1:2]);
      end
    end else if (vid_mode <= 3'd5) begin
      if (!rel[RW-1] && lane == 2'd3) begin
        nl = 2'd2;
        nk = K_BMP;
        ni = IDX_W'(rel[RW-1:2]);
      end
    end
    nv = (nk != K_NONE) && in_win && layer_on[nl];
    if (!nv) begin
      nl = 2'd0;
      nk = K_NONE;
      ni = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_vld   <= 1'b0;
      fetch_layer <= 2'd0;
      fetch_kind  <= K_NONE;
      fetch_idx   <= '0;
    end else begin
      fetch_vld   <= nv;
      fetch_layer <= nl;
      fetch_kind  <= nk;
      fetch_idx   <= ni;
    end
  end

  assert_quiet_offline_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_vis |=> !fetch_vld);
  assert_cutoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cyc > CYC_W'(LAST_CYC)) |=> !fetch_vld);
  assert_all_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_on == 4'b0000 || vid_mode >= 3'd6) |=> !fetch_vld);
  assert_bitmap_l2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_mode >= 3'd3 && vid_mode <= 3'd5) |=> (!fetch_vld || (fetch_layer == 2'd2 && fetch_kind == K_BMP)));
  assert_mixed_no_l3_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_mode == 3'd1) |=> !(fetch_vld && fetch_layer == 2'd3));
  assert_text_kinds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_mode == 3'd0) |=> (fetch_kind != K_BMP));
  assert_affine_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_mode == 3'd2 && line_cyc < CYC_W'(FIRST_CYC)) |=> !fetch_vld);
endmodule

// File: tb/sim_bg_fetch_sched.sv
`timescale 1ns/1ps
module sim_bg_fetch_sched;
  localparam int LINE_LEN = 1232;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] line_cyc = '0;
  logic        line_vis = 1'b0;
  logic [2:0]  vid_mode = '0;
  logic [3:0]  layer_on = '0;
  logic [3:0]  layer_8bpp = '0;
  logic [11:0] fine_scroll = '0;
  logic        fetch_vld;
  logic [1:0]  fetch_layer, fetch_kind;
  logic [7:0]  fetch_idx;

  int checks = 0, fails = 0;
  logic [12:0] got [0:LINE_LEN-1];

  always #10 clk = ~clk;

  bg_fetch_sched u0 (.clk(clk), .rst_n(rst_n), .line_cyc(line_cyc), .line_vis(line_vis),
    .vid_mode(vid_mode), .layer_on(layer_on), .layer_8bpp(layer_8bpp), .fine_scroll(fine_scroll),
    .fetch_vld(fetch_vld), .fetch_layer(fetch_layer), .fetch_kind(fetch_kind), .fetch_idx(fetch_idx));

  // packed expectation: {vld, layer[1:0], kind[1:0], idx[7:0]}
  function automatic logic [12:0] ref_model(int c, int m, logic [3:0] en, logic [3:0] dp,
                                            logic [11:0] fs, logic vis);
    logic [12:0] r = '0;
    int hits = 0;
    if (!vis || c > 1005) return '0;
    for (int k = 0; k < 4; k++) begin
      int kind = 0, idx = 0;
      bit txt = (m == 0) || (m == 1 && k < 2);
      bit aff = (m == 2 && k >= 2) || (m == 1 && k == 2);
      bit bmp = (m >= 3 && m <= 5 && k == 2);
      if (!en[k]) continue;
      if (txt) begin
        int s = 31 - 4 * int'(fs[3*k +: 3]);
        if (c >= s) begin
          int d = c - s, off = (c - s) % 32;
          idx = d / 32;
          if (off == k) kind = 1;
          if (off == 4 + k || off == 20 + k) kind = 2;
          if (dp[k] && (off == 12 + k || off == 28 + k)) kind = 2;
        end
      end else if (aff && c >= 31) begin
        int p = (c - 31) % 4;
        idx = (c - 31) / 4;
        if (k == 3 && p == 0) kind = 1;
        if (k == 3 && p == 1) kind = 2;
        if (k == 2 && p == 2) kind = 1;
        if (k == 2 && p == 3) kind = 2;
      end else if (bmp && c >= 31) begin
        idx = (c - 31) / 4;
        if ((c - 31) % 4 == 3) kind = 3;
      end
      if (kind != 0) begin
        hits++;
        r = {1'b1, 2'(k), 2'(kind), 8'(idx)};
      end
    end
    if (hits > 1) r = 13'h1fff;
    return r;
  endfunction

  function automatic string tag_of(int c, int m, logic [3:0] dp, logic vis);
    if (!vis || c > 1005) return "R2";
    if (m == 2) return "R7";
    if (m >= 3 && m <= 5) return "R8";
    if (m == 1) return "R9";
    if (m >= 6) return "R10";
    return (dp != 0) ? "R5" : "R4";
  endfunction

  task automatic run_line(input int m, input logic [3:0] en, input logic [3:0] dp,
                          input logic [11:0] fs, input logic vis);
    logic [12:0] e = '0;
    vid_mode = 3'(m); layer_on = en; layer_8bpp = dp; fine_scroll = fs; line_vis = vis;
    for (int c = 0; c <= LINE_LEN; c++) begin
      @(negedge clk);
      if (c > 0) begin
        logic [12:0] a = {fetch_vld, fetch_layer, fetch_kind, fetch_idx};
        got[c-1] = a;
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s cycle %0d mode %0d: actual %h expected %h",
                   tag_of(c-1, m, dp, vis), c-1, m, a, e);
        end
      end
      if (c < LINE_LEN) begin
        line_cyc = 11'(c);
        e = ref_model(c, m, en, dp, fs, vis);
      end
    end
  endtask

  task automatic spot(input string tag, input int c, input logic v, input int l,
                      input int k, input int i);
    logic [12:0] e = v ? {1'b1, 2'(l), 2'(k), 8'(i)} : 13'h0;
    checks++;
    if (got[c] !== e) begin
      fails++;
      $display("FAIL %s spot cycle %0d: actual %h expected %h", tag, c, got[c], e);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    line_vis = 1'b1; layer_on = 4'hF; vid_mode = 3'd2; line_cyc = 11'd40;
    repeat (3) @(negedge clk);
    checks++;
    if ({fetch_vld, fetch_layer, fetch_kind, fetch_idx} !== 13'h0) begin
      fails++;
      $display("FAIL R1 reset: actual %h expected 0", {fetch_vld, fetch_layer, fetch_kind, fetch_idx});
    end
    rst_n = 1'b1;

    // text, layer 0 scrolled by 3, layer 2 at 8bpp
    run_line(0, 4'hF, 4'b0100, 12'h003, 1'b1);
    spot("R3", 19, 1, 0, 1, 0);
    spot("R3", 15, 0, 0, 0, 0);
    spot("R3", 51, 1, 0, 1, 1);
    spot("R4", 23, 1, 0, 2, 0);
    spot("R4", 27, 0, 0, 0, 0);
    spot("R5", 33, 1, 2, 1, 0);
    spot("R5", 45, 1, 2, 2, 0);
    spot("R6", 1005, 1, 2, 2, 30);
    spot("R2", 1006, 0, 0, 0, 0);
    run_line(0, 4'hF, 4'hF, 12'b111_101_010_001, 1'b1);
    run_line(0, 4'b1010, 4'b0010, 12'b000_110_000_111, 1'b1);

    run_line(2, 4'hF, 4'h0, 12'h0, 1'b1);
    spot("R7", 30, 0, 0, 0, 0);
    spot("R7", 31, 1, 3, 1, 0);
    spot("R7", 32, 1, 3, 2, 0);
    spot("R7", 33, 1, 2, 1, 0);
    spot("R7", 34, 1, 2, 2, 0);
    spot("R7", 35, 1, 3, 1, 1);
    run_line(2, 4'b1000, 4'h0, 12'h0, 1'b1);
    spot("R10", 33, 0, 0, 0, 0);

    run_line(3, 4'b0100, 4'h0, 12'h0, 1'b1);
    spot("R8", 33, 0, 0, 0, 0);
    spot("R8", 34, 1, 2, 3, 0);
    spot("R8", 1002, 1, 2, 3, 242);
    run_line(5, 4'hF, 4'h0, 12'h0, 1'b1);
    run_line(4, 4'b1011, 4'h0, 12'h0, 1'b1);
    spot("R10", 34, 0, 0, 0, 0);

    run_line(1, 4'hF, 4'h0, 12'b000_000_010_000, 1'b1);
    spot("R9", 31, 1, 0, 1, 0);
    spot("R9", 33, 1, 2, 1, 0);
    spot("R9", 34, 1, 2, 2, 0);
    spot("R9", 24, 1, 1, 1, 0);
    run_line(6, 4'hF, 4'hF, 12'h0, 1'b1);
    spot("R10", 35, 0, 0, 0, 0);
    run_line(0, 4'hF, 4'hF, 12'h0, 1'b0);
    spot("R2", 31, 0, 0, 0, 0);
    finish_up();
  end
endmodule